// File: doc/BRIEF.md
# Periodic Tick and Free-Running Timer

This block combines two timing resources behind one small register interface. The first is a 16-bit down-counter. It steps on one of two divided-down tick enables and raises a level interrupt each time it passes through zero. In periodic mode it refills from a reload register. In one-shot mode it rolls over to all ones. The second is a 40-bit up-counter that runs while an enable bit is set, and software uses it as a fine timebase.

Software sets the down-counter up in two steps. It first writes the reload value and the control byte with the run bit low, then writes the control byte again with the run bit high. Software reads the lower 32 bits of the up-counter and compares them with signed differences. All tick enables are derived from the system clock by dividers, so the block has only one clock.

Top module: `tmr_unit`

## Requirements
- R1: After reset the down-counter, reload value, control byte and up-counter all read 0, the up-counter is stopped and `irq` is low.
- R2: Control byte (word address 2) bit 7 runs the down-counter, bit 6 selects periodic mode and bit 3 selects the fast tick. The control byte reads back as written. While bit 7 is 0 the count holds.
- R3: In periodic mode with reload value N-1, the down-counter reaches zero, reloads on the next selected tick and sets the interrupt, so interrupts come every N ticks.
- R4: In one-shot mode (bit 6 = 0), the tick taken at zero loads all ones into the count and sets the interrupt.
- R5: `irq` is a level that stays high until any write to word address 3. An expiry in the same cycle keeps it set.
- R6: A write to the reload register (word address 0) while stopped also loads the count at once. While running, it changes only the value used at the next reload.
- R7: The fast tick fires once every FAST_DIV system clocks and the slow tick once every SLOW_DIV system clocks. Each is a one-cycle enable.
- R8: Writing word address 5 with bit 8 = 1 starts the up-counter, which then advances by one every FRC_DIV system clocks. Writing bit 8 = 0 stops it and holds its value.
- R9: Word address 4 reads up-counter bits 31:0. Word address 5 reads bits 39:32 in bits 7:0 and the up-counter enable in bit 8. Word address 1 reads the down-counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register (combinational) |
| irq | output | 1 | Level interrupt from the down-counter |

## Verification
The bench builds the block with FAST_DIV = 2, SLOW_DIV = 5 and FRC_DIV = 3. With these values one interrupt period lasts only 8 to 15 system clocks, so many reloads, a mid-run change of the reload value and a one-shot rollover all fit in a short run. With FRC_DIV = 3, a 30-cycle window must show an advance of exactly 10 on the up-counter. The widths keep their defaults. Because of that, the 2^32 rollover of the up-counter's low word lies out of reach, and only the read layout of the high word is checked.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        ADDR_LOAD   = 3'd0,
        ADDR_COUNT  = 3'd1,
        ADDR_CTRL   = 3'd2,
        ADDR_ACK    = 3'd3,
        ADDR_FRC_LO = 3'd4,
        ADDR_FRC_HI = 3'd5
    } reg_sel_e;

    localparam int CTRL_RUN_BIT  = 7;
    localparam int CTRL_PER_BIT  = 6;
    localparam int CTRL_FAST_BIT = 3;
    localparam int FRC_EN_BIT    = 8;

    typedef struct packed {
        logic run;
        logic periodic;
        logic fast;
    } tmr_cfg_t;

    function automatic tmr_cfg_t decode_ctrl(input logic [7:0] c);
        tmr_cfg_t r;
        r.run      = c[CTRL_RUN_BIT];
        r.periodic = c[CTRL_PER_BIT];
        r.fast     = c[CTRL_FAST_BIT];
        return r;
    endfunction

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst)              cnt <= '0;
                else if (cnt == LAST) cnt <= '0;
                else                  cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/tmr_periodic.sv
module tmr_periodic #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         run,
    input  logic         periodic,
    input  logic         ld_we,
    input  logic [W-1:0] ld_val,
    input  logic         ack,
    output logic [W-1:0] count,
    output logic [W-1:0] reload,
    output logic         expire,
    output logic         irq
);
    assign expire = run && tick && (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            reload <= '0;
        end else begin
            if (ld_we) reload <= ld_val;
            if (!run) begin
                if (ld_we) count <= ld_val;
            end else if (tick) begin
                if (count == '0) count <= periodic ? reload : '1;
                else             count <= count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         irq <= 1'b0;
        else if (expire) irq <= 1'b1;
        else if (ack)    irq <= 1'b0;
    end
endmodule

// File: rtl/tmr_freerun.sv
module tmr_freerun #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         en_we,
    input  logic         en_val,
    output logic         en,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en  <= 1'b0;
            cnt <= '0;
        end else begin
            if (en_we)       en  <= en_val;
            if (en && tick)  cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int LOAD_W   = 16,
    parameter int FRC_W    = 40,
    parameter int FAST_DIV = 98,
    parameter int SLOW_DIV = 25000,
    parameter int FRC_DIV  = 51
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq
);
    localparam int HI_W = FRC_W - 32;

    logic              fast_tick, slow_tick, frc_tick, sel_tick;
    logic [7:0]        ctrl_q;
    tmr_cfg_t          cfg;
    logic [LOAD_W-1:0] tmr_count, tmr_reload;
    logic              tmr_expire;
    logic              frc_en;
    logic [FRC_W-1:0]  frc_cnt;
    logic              we_load, we_ctrl, we_ack, we_hi;

    assign we_load = wr_en && (addr == ADDR_LOAD);
    assign we_ctrl = wr_en && (addr == ADDR_CTRL);
    assign we_ack  = wr_en && (addr == ADDR_ACK);
    assign we_hi   = wr_en && (addr == ADDR_FRC_HI);

    tmr_tick_gen #(.DIV(FAST_DIV)) u_fast (.clk(clk), .rst(rst), .tick(fast_tick));
    tmr_tick_gen #(.DIV(SLOW_DIV)) u_slow (.clk(clk), .rst(rst), .tick(slow_tick));
    tmr_tick_gen #(.DIV(FRC_DIV))  u_frct (.clk(clk), .rst(rst), .tick(frc_tick));

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (we_ctrl) ctrl_q <= wdata[7:0];
    end

    assign cfg      = decode_ctrl(ctrl_q);
    assign sel_tick = cfg.fast ? fast_tick : slow_tick;

    tmr_periodic #(.W(LOAD_W)) u_per (
        .clk(clk), .rst(rst), .tick(sel_tick), .run(cfg.run),
        .periodic(cfg.periodic), .ld_we(we_load), .ld_val(wdata[LOAD_W-1:0]),
        .ack(we_ack), .count(tmr_count), .reload(tmr_reload),
        .expire(tmr_expire), .irq(irq)
    );

    tmr_freerun #(.W(FRC_W)) u_frc (
        .clk(clk), .rst(rst), .tick(frc_tick), .en_we(we_hi),
        .en_val(wdata[FRC_EN_BIT]), .en(frc_en), .cnt(frc_cnt)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_LOAD:   rdata[LOAD_W-1:0] = tmr_reload;
            ADDR_COUNT:  rdata[LOAD_W-1:0] = tmr_count;
            ADDR_CTRL:   rdata[7:0]        = ctrl_q;
            ADDR_FRC_LO: rdata             = frc_cnt[31:0];
            ADDR_FRC_HI: begin
                rdata[HI_W-1:0]   = frc_cnt[FRC_W-1:32];
                rdata[FRC_EN_BIT] = frc_en;
            end
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk
    import tmr_pkg::*;
#(
    parameter int LOAD_W = 16,
    parameter int FRC_W  = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [2:0]        addr,
    input logic              irq,
    input logic              run,
    input logic              expire,
    input logic [LOAD_W-1:0] count,
    input logic              frc_en,
    input logic              frc_tick,
    input logic [FRC_W-1:0]  frc_cnt
);
    // R5
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_ACK && !expire) |=> !irq);

    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !(wr_en && addr == ADDR_ACK)) |=> irq);

    // R3
    expire_irq_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> irq);

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !(wr_en && addr == ADDR_LOAD)) |=> $stable(count));

    // R8
    frc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (frc_en && frc_tick) |=> (frc_cnt == $past(frc_cnt) + 1'b1));

    // R8
    frc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(frc_en && frc_tick) |=> $stable(frc_cnt));
endmodule

bind tmr_unit tmr_unit_chk #(.LOAD_W(LOAD_W), .FRC_W(FRC_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .irq(irq),
    .run(cfg.run), .expire(tmr_expire), .count(tmr_count),
    .frc_en(frc_en), .frc_tick(frc_tick), .frc_cnt(frc_cnt)
);

// File: tb/tmr_unit_tb.sv
module tmr_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        drv_we = 1'b0;
    logic [2:0]  drv_addr = 3'd0;
    logic [31:0] wdata = '0;
    logic        mon_ack = 1'b0;
    logic        wr_en;
    logic [2:0]  addr;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycle = 0;
    bit auto_ack = 1'b0;
    bit done = 1'b0;
    int exp_q[$];

    assign wr_en = drv_we | mon_ack;
    assign addr  = mon_ack ? 3'd3 : drv_addr;

    always #5 clk = ~clk;
    always @(posedge clk) cycle <= cycle + 1;

    tmr_unit #(.FAST_DIV(2), .SLOW_DIV(5), .FRC_DIV(3)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        drv_we = 1'b1; drv_addr = a; wdata = d;
        @(negedge clk);
        drv_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        drv_addr = a;
        #1 d = rdata;
    endtask

    // monitor: measure rise-to-rise interval of irq and compare with queue
    logic irq_q = 1'b0;
    int   last_rise = 0;
    always @(negedge clk) begin
        if (mon_ack) mon_ack <= 1'b0;
        if (!rst && irq && !irq_q) begin
            if (exp_q.size() > 0) begin
                int e;
                e = exp_q.pop_front();
                if (e != 0)
                    check(cycle - last_rise == e, "R3/R7 period", cycle - last_rise, e);
            end
            last_rise = cycle;
            if (auto_ack) mon_ack <= 1'b1;
        end
        irq_q <= irq && !mon_ack;
    end

    initial begin
        logic [31:0] v, v2;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd1, v); check(v == 0, "R1 count", v, 0);
        rd(3'd2, v); check(v == 0, "R1 ctrl", v, 0);
        rd(3'd4, v); check(v == 0, "R1 frc lo", v, 0);
        rd(3'd5, v); check(v == 0, "R1 frc hi", v, 0);
        check(irq == 0, "R1 irq", irq, 0);

        // R6 load while stopped loads count too
        wr(3'd0, 32'd3);
        rd(3'd1, v); check(v == 3, "R6 stopped load", v, 3);
        rd(3'd0, v); check(v == 3, "R6 reload reg", v, 3);

        // R2 configured but not running: count holds
        wr(3'd2, 32'h48);
        repeat (20) @(negedge clk);
        rd(3'd1, v); check(v == 3, "R2 hold", v, 3);
        check(irq == 0, "R2 no irq", irq, 0);
        rd(3'd2, v); check(v == 32'h48, "R2 readback", v, 32'h48);

        // R3 R7 fast periodic: 4 ticks * 2 clocks
        auto_ack = 1'b1;
        exp_q.push_back(0); exp_q.push_back(8); exp_q.push_back(8); exp_q.push_back(8);
        wr(3'd2, 32'hC8);
        rd(3'd2, v); check(v == 32'hC8, "R2 readback run", v, 32'hC8);
        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);

        // R7 slow tick: 3 ticks * 5 clocks
        wr(3'd2, 32'h40);
        wr(3'd0, 32'd2);
        exp_q.push_back(0); exp_q.push_back(15); exp_q.push_back(15);
        wr(3'd2, 32'hC0);
        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);

        // R6 reload write while running affects only next reload
        exp_q.push_back(0);
        wr(3'd2, 32'hC8);
        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
        wr(3'd0, 32'd5);
        rd(3'd1, v); check(v <= 2, "R6 running load not immediate", v, 2);
        exp_q.push_back(0); exp_q.push_back(12); exp_q.push_back(12);
        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);

        // R5 level interrupt held until clear
        auto_ack = 1'b0;
        while (!irq) @(negedge clk);
        wr(3'd2, 32'h48);
        repeat (20) @(negedge clk);
        check(irq == 1, "R5 irq held", irq, 1);
        wr(3'd3, 32'd0);
        check(irq == 0, "R5 irq cleared", irq, 0);

        // R4 one-shot rolls over to all ones
        wr(3'd0, 32'd3);
        wr(3'd2, 32'h88);
        while (!irq) @(negedge clk);
        rd(3'd1, v); check(v >= 32'hFFF0 && v <= 32'hFFFF, "R4 rollover", v, 32'hFFFF);
        wr(3'd2, 32'h08);
        wr(3'd3, 32'd0);
        check(irq == 0, "R4 irq cleared", irq, 0);

        // R8 R9 free-running counter
        repeat (10) @(negedge clk);
        rd(3'd4, v); check(v == 0, "R8 stopped frc", v, 0);
        wr(3'd5, 32'h100);
        rd(3'd5, v); check(v == 32'h100, "R9 hi layout", v, 32'h100);
        rd(3'd4, v);
        repeat (30) @(negedge clk);
        #1 v2 = rdata;
        check(v2 - v == 10, "R8 rate", v2 - v, 10);
        wr(3'd5, 32'h0);
        rd(3'd4, v);
        repeat (20) @(negedge clk);
        rd(3'd4, v2); check(v2 == v, "R8 stop holds", v2, v);
        rd(3'd5, v); check(v == 0, "R9 hi enable cleared", v, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycle, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule